// File: doc/BRIEF.md
# Packed Colour Palette with Output Format Conversion

This block holds a 256-colour lookup table for a display pipeline. The storage is organised as 128 words of 32 bits, and each word carries two 16-bit colour entries. A register interface writes whole words and reads them back unchanged.

A separate lookup port takes an 8-bit pixel index and returns that entry's colour, repacked into one of four output pixel layouts chosen by a format code. Each stored entry has three 5-bit channels, and each channel is first widened to 8 bits by appending three zero bits. The requested layout is then cut from the widened channels. One bit of every entry is a brightness flag that this block does not use.

The lookup result is registered. It appears one cycle after the request, with a valid flag that follows the request's valid flag.

Top module: `pal_lut`

## Requirements
- R1: Palette word n holds entry 2n in bits [15:0] and entry 2n+1 in bits [31:16]. A lookup with index i uses word i>>1, and bit 0 of i selects the upper half when set.
- R2: Within an entry, red is bits [4:0], green is bits [9:5] and blue is bits [14:10]. Bit 15 has no effect on any lookup result.
- R3: Format code 0 gives out_pixel[7:0] = {red[4:2], green[4:2], blue[4:3]}, with out_pixel[23:8] zero.
- R4: Format code 1 gives out_pixel[14:0] = {red, green, blue}, with out_pixel[23:15] zero.
- R5: Format code 2 gives out_pixel[15:0] = {red, green, 1'b0, blue}, with out_pixel[23:16] zero.
- R6: Format code 3 gives out_pixel = {red, 3'b000, green, 3'b000, blue, 3'b000}.
- R7: A lookup presented with lk_valid high at a rising edge produces out_valid high and its out_pixel in the following cycle. out_valid is low in a cycle that follows no request.
- R8: out_pixel holds its value through cycles that follow no lookup request.
- R9: rd_data returns, all 32 bits included, the last value written to the word selected by rd_addr. It shows the new value in the cycle after the write edge.
- R10: A lookup to an entry whose word is written at the same edge returns the newly written colour.
- R11: While reset is asserted and after it is released, out_valid and out_pixel are zero until the first lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the lookup output |
| wr_en | input | 1 | Word write strobe |
| wr_addr | input | 7 | Word address for the write |
| wr_data | input | 32 | Word holding two packed entries |
| rd_addr | input | 7 | Word address for raw readback |
| rd_data | output | 32 | Raw word at rd_addr |
| lk_valid | input | 1 | Lookup request |
| lk_index | input | 8 | Pixel index to look up |
| lk_fmt | input | 2 | Output layout: 0 = 3:3:2, 1 = 5:5:5, 2 = 5:6:5, 3 = 8:8:8 |
| out_valid | output | 1 | Lookup result valid |
| out_pixel | output | 24 | Converted colour, zero-extended |

## Verification
The hardest case to reach from the ports is a lookup to a word at the same clock edge that writes it. Without forwarding, that lookup returns the stale colour, and only that edge shows the difference. The bench first fills the word with a known value. It then issues the write and the lookup to both halves of that word together, so the only correct answer is the new colour. Bit 15 is also hard to observe, because it never reaches a lookup result. The bench covers it in two ways: it writes words with only the brightness bits set and checks that every format yields zero, and it sets those bits in most words of the full sweep.

// File: rtl/pal_lut.sv
module pal_lut #(
  parameter int WORDS = 128,
  localparam int AW = $clog2(WORDS),
  localparam int IW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  input  logic          lk_valid,
  input  logic [IW-1:0] lk_index,
  input  logic [1:0]    lk_fmt,
  output logic          out_valid,
  output logic [23:0]   out_pixel
);

  logic [31:0] mem [WORDS];

  always_ff @(posedge clk)
    if (wr_en) mem[wr_addr] <= wr_data;

  assign rd_data = mem[rd_addr];

  logic [AW-1:0] lk_word;
  logic          fwd;
  logic [14:0]   ent;
  logic [4:0]    r5, g5, b5;
  logic [23:0]   pix;

  assign lk_word = lk_index[IW-1:1];
  assign fwd     = wr_en && (wr_addr == lk_word);

  always_comb begin
    if (lk_index[0]) ent = fwd ? wr_data[30:16] : mem[lk_word][30:16];
    else             ent = fwd ? wr_data[14:0]  : mem[lk_word][14:0];
  end

  assign r5 = ent[4:0];
  assign g5 = ent[9:5];
  assign b5 = ent[14:10];

  always_comb begin
    case (lk_fmt)
      2'd0:    pix = {16'd0, r5[4:2], g5[4:2], b5[4:3]};
      2'd1:    pix = {9'd0, r5, g5, b5};
      2'd2:    pix = {8'd0, r5, g5, 1'b0, b5};
      default: pix = {r5, 3'd0, g5, 3'd0, b5, 3'd0};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pixel <= '0;
    end else begin
      out_valid <= lk_valid;
      if (lk_valid) out_pixel <= pix;
    end
  end

endmodule

// File: rtl/pal_lut_chk.sv
module pal_lut_chk #(
  parameter int WORDS = 128,
  localparam int AW = $clog2(WORDS),
  localparam int IW = AW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [31:0]   wr_data,
  input logic [AW-1:0] rd_addr,
  input logic [31:0]   rd_data,
  input logic          lk_valid,
  input logic [IW-1:0] lk_index,
  input logic [1:0]    lk_fmt,
  input logic          out_valid,
  input logic [23:0]   out_pixel
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) lk_valid |=> out_valid); // R7
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n) !lk_valid |=> !out_valid); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !lk_valid |=> $stable(out_pixel)); // R8
  AST_FMT0_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (lk_valid && lk_fmt == 2'd0) |=> out_pixel[23:8] == 16'd0); // R3
  AST_FMT1_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (lk_valid && lk_fmt == 2'd1) |=> out_pixel[23:15] == 9'd0); // R4
  AST_FMT2_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (lk_valid && lk_fmt == 2'd2) |=> (out_pixel[23:16] == 8'd0 && !out_pixel[5])); // R5
  AST_FMT3_PAD: assert property (@(posedge clk) disable iff (!rst_n) (lk_valid && lk_fmt == 2'd3) |=> (out_pixel & 24'h070707) == 24'd0); // R6
  AST_RAW_READBACK: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && rd_addr == wr_addr) |=> ($stable(rd_addr) -> rd_data == $past(wr_data))); // R9

endmodule

bind pal_lut pal_lut_chk #(.WORDS(WORDS)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data), .lk_valid(lk_valid), .lk_index(lk_index),
  .lk_fmt(lk_fmt), .out_valid(out_valid), .out_pixel(out_pixel)
);

// File: tb/pal_lut_tb_top.sv
module pal_lut_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [6:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        lk_valid = 1'b0;
  logic [7:0]  lk_index = '0;
  logic [1:0]  lk_fmt = '0;
  logic        out_valid;
  logic [23:0] out_pixel;

  int errors = 0;
  int checks = 0;
  logic [31:0] model [128];

  always #2.5 clk = ~clk;

  pal_lut dut_i (.*);

  function automatic int unsigned expect_px(input logic [31:0] w, input int hi, input int f);
    int unsigned e, r, g, b;
    e = hi ? (w >> 16) : (w & 32'hFFFF);
    r = e % 32;
    g = (e / 32) % 32;
    b = (e / 1024) % 32;
    case (f)
      0: return (r / 4) * 32 + (g / 4) * 4 + (b / 8);
      1: return r * 1024 + g * 32 + b;
      2: return r * 2048 + g * 64 + b;
      default: return r * 8 * 65536 + g * 8 * 256 + b * 8;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int unsigned act, input int unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_word(input int n, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = n[6:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model[n] = d;
  endtask

  task automatic lookup(input int idx, input int f, input string req);
    int unsigned exp;
    @(negedge clk);
    lk_valid = 1'b1; lk_index = idx[7:0]; lk_fmt = f[1:0];
    @(negedge clk);
    lk_valid = 1'b0;
    exp = expect_px(model[idx / 2], idx % 2, f);
    check(out_valid == 1'b1, req, {31'd0, out_valid}, 1);
    check(out_pixel == exp[23:0], req, out_pixel, exp);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(out_valid == 1'b0 && out_pixel == 24'd0, "R11", out_pixel, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && out_pixel == 24'd0, "R11", out_pixel, 0);

    // fill every word, bit 15/31 set in most words (R2)
    for (int n = 0; n < 128; n++)
      write_word(n, (n * 32'h9E3779B1) ^ 32'h80008000 ^ (n * 32'h00010203));

    // R9 raw readback of every word
    for (int n = 0; n < 128; n++) begin
      rd_addr = n[6:0];
      #1;
      check(rd_data == model[n], "R9", rd_data, model[n]);
    end

    // R1 R3 R4 R5 R6 full sweep
    for (int f = 0; f < 4; f++)
      for (int i = 0; i < 256; i++)
        lookup(i, f, f == 0 ? "R1/R3" : f == 1 ? "R1/R4" : f == 2 ? "R1/R5" : "R1/R6");

    // R2 brightness bits alone give black in every format
    write_word(9, 32'h80008000);
    for (int f = 0; f < 4; f++) begin
      lookup(18, f, "R2");
      lookup(19, f, "R2");
    end
    // R2 channel placement, single channel full scale
    write_word(9, 32'h03E0001F);
    lookup(18, 3, "R2");
    lookup(19, 3, "R2");
    write_word(9, 32'h7C00FFFF);
    lookup(18, 1, "R2");
    lookup(19, 1, "R2");

    // R8 hold with no request while index and format change
    lookup(7, 3, "R8");
    begin
      logic [23:0] held;
      held = out_pixel;
      @(negedge clk);
      lk_index = 8'd200; lk_fmt = 2'd0;
      @(negedge clk);
      @(negedge clk);
      check(out_pixel == held, "R8", out_pixel, held);
      check(out_valid == 1'b0, "R7", {31'd0, out_valid}, 0);
    end

    // R10 same-edge write and lookup, both halves
    write_word(5, 32'h00000000);
    for (int h = 0; h < 2; h++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 7'd5; wr_data = 32'h5A5A7FFF ^ (h * 32'h11110000);
      lk_valid = 1'b1; lk_index = 8'(10 + h); lk_fmt = 2'd3;
      @(negedge clk);
      wr_en = 1'b0; lk_valid = 1'b0;
      model[5] = 32'h5A5A7FFF ^ (h * 32'h11110000);
      check(out_pixel == expect_px(model[5], h, 3), "R10", out_pixel, expect_px(model[5], h, 3));
    end

    // R9 readback after overwrite
    rd_addr = 7'd5;
    #1;
    check(rd_data == model[5], "R9", rd_data, model[5]);

    // R7 back-to-back lookups
    @(negedge clk);
    lk_valid = 1'b1; lk_index = 8'd0; lk_fmt = 2'd1;
    @(negedge clk);
    check(out_valid && out_pixel == expect_px(model[0], 0, 1), "R7", out_pixel, expect_px(model[0], 0, 1));
    lk_index = 8'd255; lk_fmt = 2'd2;
    @(negedge clk);
    lk_valid = 1'b0;
    check(out_valid && out_pixel == expect_px(model[127], 1, 2), "R7", out_pixel, expect_px(model[127], 1, 2));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule